// File: doc/BRIEF.md
# Serial Flash Status and Write-Protection Guard

This block holds the status byte of a 16-Mbit serial NOR flash and decides whether each modifying command may proceed. Commands arrive already decoded, as single-cycle strobes. They cover arming and disarming the write-enable latch, writing the status byte, programming a page, erasing one sector and erasing the whole chip. A 21-bit target address and an active-low write-protect pin come with them. Serial shifting, the storage array and true non-volatile cells are outside the block. The bits that would be non-volatile are ordinary flops that reset to zero.

An accepted command is answered with a one-cycle accept pulse. It then holds the busy flag high for a programmable number of clocks. A refused command is answered with a one-cycle reject pulse and changes nothing. The status byte is always on the output, ready for a read-status command.

Top module: `sflash_guard`

## Requirements
- R1: The status byte is {lock, 0, from_low, prot_lvl[2:0], armed, active}, bit 7 to bit 0. It reads 0x00 after reset, and bit 6 always reads 0.
- R2: An accepted status-write, program or erase pulses `accept` on the cycle after its strobe. From that cycle, `active` and `busy` stay high for `cycle_len` clocks, or for 1 clock when `cycle_len` is 0.
- R3: `cmd_arm` sets `armed` and `cmd_disarm` clears it, also while busy. `armed` clears on the clock edge that ends an accepted cycle, unless `cmd_arm` strobes in that same cycle.
- R4: While `armed` is 0, a status-write, program or erase command pulses `reject` and leaves the status byte unchanged.
- R5: Program and sector erase are rejected when the address sector (`addr[20:16]`, 32 sectors of 64 KB) lies in the protected region. For prot_lvl n from 1 to 6 the region is 2^(n-1) sectors; for 7 it is all 32 sectors. With from_low=0 the region is counted from sector 31 downward; with from_low=1 it is counted from sector 0 upward. prot_lvl 0 protects nothing.
- R6: Chip erase is accepted only when prot_lvl is 0; otherwise it is rejected.
- R7: While lock=1 and `wprot_n`=0, a status write is rejected and lock, from_low and prot_lvl keep their values. With `wprot_n`=1 the status write proceeds normally.
- R8: An accepted status write loads `wr_data[7]` into lock, `wr_data[5]` into from_low and `wr_data[4:2]` into prot_lvl. `wr_data[6]` and `wr_data[1:0]` are ignored.
- R9: While busy, status-write, program and erase strobes are ignored: neither pulse occurs and the status byte is untouched.
- R10: When several strobes coincide, only the first in the order arm, disarm, status write, program, sector erase, chip erase is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_arm | input | 1 | Set write-enable latch strobe |
| cmd_disarm | input | 1 | Clear write-enable latch strobe |
| cmd_stat_wr | input | 1 | Status write strobe |
| cmd_prog | input | 1 | Page program strobe |
| cmd_sect_erase | input | 1 | Sector erase strobe |
| cmd_chip_erase | input | 1 | Whole-array erase strobe |
| wr_data | input | 8 | Data byte for a status write |
| addr | input | 21 | Target byte address |
| wprot_n | input | 1 | Write-protect pin, active low |
| cycle_len | input | 8 | Busy length of an accepted cycle in clocks |
| status | output | 8 | Status byte |
| accept | output | 1 | Command accepted pulse |
| reject | output | 1 | Command refused pulse |
| busy | output | 1 | Internal cycle running |

## Verification
Some properties are checked by assertions on every clock:
- an accept always follows an armed, idle state;
- an accept always raises busy;
- a chip erase is never accepted with nonzero protection;
- a program or sector erase is never accepted inside the protected region;
- the protection bits never move while the hardware lock holds;
- accept and reject never pulse together.

Other behaviours come only from the bench's scenarios, compared against a behavioural model: the exact busy length, the region sizes at every protection level and at both ends of the array, the coincidence of strobes, and the latch being cleared when a cycle completes.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ARM,
        OP_DISARM,
        OP_STAT_WR,
        OP_PROG,
        OP_SECT_ERASE,
        OP_CHIP_ERASE
    } sfg_op_t;

    typedef struct packed {
        logic       lock;
        logic       from_low;
        logic [2:0] prot_lvl;
        logic       armed;
    } sfg_stat_t;

    localparam sfg_stat_t STAT_RESET = '{lock: 1'b0, from_low: 1'b0, prot_lvl: 3'd0, armed: 1'b0};

endpackage

// File: rtl/sfg_region.sv
module sfg_region #(
    parameter int SECT_W = 5
) (
    input  logic [2:0]        prot_lvl,
    input  logic              from_low,
    input  logic [SECT_W-1:0] sector,
    output logic              hit
);
    localparam logic [SECT_W:0] ONE  = {{SECT_W{1'b0}}, 1'b1};
    localparam logic [SECT_W:0] FULL = ONE << SECT_W;

    logic [SECT_W:0] span;
    logic [SECT_W:0] sec_ext;

    always_comb begin
        sec_ext = {1'b0, sector};
        if (prot_lvl == 3'd0) begin
            span = '0;
        end else if (int'(prot_lvl) > SECT_W) begin
            span = FULL;
        end else begin
            span = ONE << (prot_lvl - 3'd1);
        end
        if (span == '0) begin
            hit = 1'b0;
        end else if (from_low) begin
            hit = sec_ext < span;
        end else begin
            hit = sec_ext >= (FULL - span);
        end
    end

endmodule

// File: rtl/sfg_timer.sv
module sfg_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = (len == '0) ? {{(CNT_W-1){1'b0}}, 1'b1} : len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

    AST_TIMER_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R9

endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
    import sfg_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int SECTORS = 32,
    parameter int CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_arm,
    input  logic              cmd_disarm,
    input  logic              cmd_stat_wr,
    input  logic              cmd_prog,
    input  logic              cmd_sect_erase,
    input  logic              cmd_chip_erase,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wprot_n,
    input  logic [CNT_W-1:0]  cycle_len,
    output logic [7:0]        status,
    output logic              accept,
    output logic              reject,
    output logic              busy
);
    localparam int SECT_W = $clog2(SECTORS);

    typedef struct packed {
        sfg_stat_t st;
        logic      acc;
        logic      rej;
    } guard_t;

    guard_t  g_d, g_q;
    sfg_op_t op;
    logic    hit, hw_lock, start, tmr_busy, tmr_done;

    sfg_region #(.SECT_W(SECT_W)) u_region (
        .prot_lvl (g_q.st.prot_lvl),
        .from_low (g_q.st.from_low),
        .sector   (addr[ADDR_W-1 -: SECT_W]),
        .hit      (hit)
    );

    sfg_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len   (cycle_len),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    // fixed priority among coincident strobes
    always_comb begin
        if (cmd_arm)             op = OP_ARM;
        else if (cmd_disarm)     op = OP_DISARM;
        else if (cmd_stat_wr)    op = OP_STAT_WR;
        else if (cmd_prog)       op = OP_PROG;
        else if (cmd_sect_erase) op = OP_SECT_ERASE;
        else if (cmd_chip_erase) op = OP_CHIP_ERASE;
        else                     op = OP_NONE;
    end

    assign hw_lock = g_q.st.lock && !wprot_n;

    always_comb begin
        g_d     = g_q;
        g_d.acc = 1'b0;
        g_d.rej = 1'b0;
        start   = 1'b0;
        if (tmr_done) begin
            g_d.st.armed = 1'b0;
        end
        unique case (op)
            OP_ARM:    g_d.st.armed = 1'b1;
            OP_DISARM: g_d.st.armed = 1'b0;
            OP_STAT_WR: begin
                if (!tmr_busy) begin
                    if (!g_q.st.armed || hw_lock) begin
                        g_d.rej = 1'b1;
                    end else begin
                        g_d.acc         = 1'b1;
                        start           = 1'b1;
                        g_d.st.lock     = wr_data[7];
                        g_d.st.from_low = wr_data[5];
                        g_d.st.prot_lvl = wr_data[4:2];
                    end
                end
            end
            OP_PROG, OP_SECT_ERASE: begin
                if (!tmr_busy) begin
                    if (!g_q.st.armed || hit) begin
                        g_d.rej = 1'b1;
                    end else begin
                        g_d.acc = 1'b1;
                        start   = 1'b1;
                    end
                end
            end
            OP_CHIP_ERASE: begin
                if (!tmr_busy) begin
                    if (!g_q.st.armed || (g_q.st.prot_lvl != 3'd0)) begin
                        g_d.rej = 1'b1;
                    end else begin
                        g_d.acc = 1'b1;
                        start   = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{st: STAT_RESET, acc: 1'b0, rej: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

    assign status = {g_q.st.lock, 1'b0, g_q.st.from_low, g_q.st.prot_lvl, g_q.st.armed, tmr_busy};
    assign accept = g_q.acc;
    assign reject = g_q.rej;
    assign busy   = tmr_busy;

    AST_ACCEPT_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ($past(status[1]) && !$past(busy))); // R4
    AST_ACCEPT_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (busy && status[0])); // R2
    AST_CHIP_ERASE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(op == OP_CHIP_ERASE)) |-> ($past(status[4:2]) == 3'd0)); // R6
    AST_REGION_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && $past(op == OP_PROG || op == OP_SECT_ERASE)) |-> !$past(hit)); // R5
    AST_HW_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(status[7] && !wprot_n) |-> $stable(status[7:2])); // R7
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject)); // R10
    AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status[6]); // R1

endmodule

// File: tb/tb_sflash_guard.sv
module tb_sflash_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_arm = 0, cmd_disarm = 0, cmd_stat_wr = 0;
    logic        cmd_prog = 0, cmd_sect_erase = 0, cmd_chip_erase = 0;
    logic [7:0]  wr_data = '0;
    logic [20:0] addr = '0;
    logic        wprot_n = 1'b1;
    logic [7:0]  cycle_len = 8'd3;
    logic [7:0]  status;
    logic        accept, reject, busy;

    int vectors = 0;
    int fails = 0;
    bit finished = 0;

    // reference model state
    int    m_lock = 0, m_low = 0, m_lvl = 0, m_armed = 0, m_cnt = 0;
    int    m_acc = 0, m_rej = 0;
    string tag = "R1";

    always #10 clk = ~clk;

    sflash_guard dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_arm(cmd_arm), .cmd_disarm(cmd_disarm), .cmd_stat_wr(cmd_stat_wr),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase), .cmd_chip_erase(cmd_chip_erase),
        .wr_data(wr_data), .addr(addr), .wprot_n(wprot_n), .cycle_len(cycle_len),
        .status(status), .accept(accept), .reject(reject), .busy(busy)
    );

    function automatic bit in_region(int lvl, int low, int a);
        int sec = a >> 16;
        int span;
        if (lvl == 0) return 0;
        span = (lvl >= 6) ? 32 : (1 << (lvl - 1));
        if (low != 0) return sec < span;
        return sec >= 32 - span;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lock = 0; m_low = 0; m_lvl = 0; m_armed = 0; m_cnt = 0; m_acc = 0; m_rej = 0;
        end else begin
            int  n;
            bit  was_busy;
            was_busy = (m_cnt != 0);
            m_acc = 0; m_rej = 0;
            if (m_cnt == 1) m_armed = 0;      // R3 cleared at completion
            if (m_cnt > 0) m_cnt--;
            n = cmd_arm + cmd_disarm + cmd_stat_wr + cmd_prog + cmd_sect_erase + cmd_chip_erase;
            if (cmd_arm) begin
                m_armed = 1; tag = "R3";
            end else if (cmd_disarm) begin
                m_armed = 0; tag = "R3";
            end else if (n > 0 && was_busy) begin
                tag = "R9";
            end else if (n > 0 && m_armed == 0) begin
                m_rej = 1; tag = "R4";
            end else if (cmd_stat_wr) begin
                if (m_lock != 0 && !wprot_n) begin
                    m_rej = 1; tag = "R7";
                end else begin
                    m_acc = 1; tag = "R8";
                    m_lock = wr_data[7]; m_low = wr_data[5]; m_lvl = wr_data[4:2];
                end
            end else if (cmd_prog || cmd_sect_erase) begin
                tag = "R5";
                if (in_region(m_lvl, m_low, addr)) m_rej = 1;
                else m_acc = 1;
            end else if (cmd_chip_erase) begin
                tag = "R6";
                if (m_lvl != 0) m_rej = 1;
                else m_acc = 1;
            end
            if (m_acc != 0) m_cnt = (cycle_len == 0) ? 1 : cycle_len;
            if (n > 1) tag = "R10";
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [7:0] exp;
            exp = {m_lock[0], 1'b0, m_low[0], m_lvl[2:0], m_armed[0], (m_cnt != 0)};
            vectors++;
            if (status !== exp) begin
                fails++;
                $display("FAIL %s status actual=%02h expected=%02h", tag, status, exp);
            end
            if (busy !== (m_cnt != 0)) begin
                fails++;
                $display("FAIL R2 busy actual=%0b expected=%0b", busy, (m_cnt != 0));
            end
            if (accept !== m_acc[0] || reject !== m_rej[0]) begin
                fails++;
                $display("FAIL %s accept/reject actual=%0b%0b expected=%0b%0b",
                         tag, accept, reject, m_acc[0], m_rej[0]);
            end
        end
    end

    task automatic issue(input bit [5:0] s, input logic [7:0] d, input int a);
        @(negedge clk);
        {cmd_arm, cmd_disarm, cmd_stat_wr, cmd_prog, cmd_sect_erase, cmd_chip_erase} = s;
        wr_data = d;
        addr = 21'(a);
        @(negedge clk);
        {cmd_arm, cmd_disarm, cmd_stat_wr, cmd_prog, cmd_sect_erase, cmd_chip_erase} = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    localparam bit [5:0] S_ARM = 6'b100000, S_DIS = 6'b010000, S_SW = 6'b001000;
    localparam bit [5:0] S_PG = 6'b000100, S_SE = 6'b000010, S_CE = 6'b000001;

    function automatic int sec_addr(int s);
        return (s << 16) | 16'h1234;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        vectors++;                                   // R1 reset value
        if (status !== 8'h00) begin
            fails++;
            $display("FAIL R1 reset status actual=%02h expected=00", status);
        end
        issue(S_PG, 0, sec_addr(3));                 // R4 not armed
        issue(S_ARM, 0, 0);
        issue(S_SW, 8'b0100_1111, 0);                // R8 lvl 3, ignored bits set
        settle(5);                                   // R2 busy three clocks
        issue(S_ARM, 0, 0);
        issue(S_PG, 0, sec_addr(31));                // R5 top region rejects
        issue(S_PG, 0, sec_addr(28));
        issue(S_SE, 0, sec_addr(27));                // R5 just outside region
        issue(S_PG, 0, sec_addr(0));                 // R9 ignored while busy
        settle(4);
        issue(S_ARM, 0, 0);
        cycle_len = 8'd6;
        issue(S_SE, 0, sec_addr(1));
        issue(S_ARM, 0, 0);                          // R3 arm while busy
        issue(S_DIS, 0, 0);                          // R3 disarm while busy
        settle(6);
        issue(S_ARM, 0, 0);
        issue(S_CE, 0, 0);                           // R6 rejected, lvl nonzero
        cycle_len = 8'd0;                            // R2 zero means one clock
        issue(S_SW, 8'b0010_0100, 0);                // R8 bottom, lvl 1
        settle(2);
        issue(S_ARM, 0, 0);
        issue(S_PG, 0, sec_addr(0));                 // R5 bottom region
        issue(S_PG, 0, sec_addr(1));
        settle(2);
        for (int lv = 2; lv < 8; lv++) begin         // R5 every level, both ends
            for (int lo = 0; lo < 2; lo++) begin
                issue(S_ARM, 0, 0);
                issue(S_SW, 8'((lo << 5) | (lv << 2)), 0);
                settle(2);
                for (int k = 0; k < 5; k++) begin
                    issue(S_ARM, 0, 0);
                    issue(S_SE, 0, sec_addr((k * 9 + lv) % 32));
                    settle(2);
                end
            end
        end
        cycle_len = 8'd2;
        issue(S_ARM, 0, 0);
        issue(S_SW, 8'b1000_1000, 0);                // lock set, lvl 2
        settle(3);
        wprot_n = 1'b0;
        issue(S_ARM, 0, 0);
        issue(S_SW, 8'h00, 0);                       // R7 hardware lock rejects
        wprot_n = 1'b1;
        issue(S_SW, 8'h00, 0);                       // R7 pin high allows
        settle(3);
        issue(S_ARM, 0, 0);
        issue(S_CE, 0, 0);                           // R6 accepted at lvl 0
        settle(3);
        issue(S_ARM | S_SW, 8'h0C, 0);               // R10 arm wins
        issue(S_DIS | S_PG, 0, sec_addr(2));         // R10 disarm wins
        issue(S_ARM, 0, 0);
        issue(S_SW | S_CE, 8'h14, 0);                // R10 status write wins
        settle(3);
        for (int i = 0; i < 3000; i++) begin         // mixed traffic
            @(negedge clk);
            {cmd_arm, cmd_disarm, cmd_stat_wr, cmd_prog, cmd_sect_erase, cmd_chip_erase} =
                ($urandom_range(0, 2) == 0) ? 6'($urandom) : (6'd1 << $urandom_range(0, 5));
            wr_data   = 8'($urandom);
            addr      = 21'($urandom);
            wprot_n   = ($urandom_range(0, 3) != 0);
            cycle_len = 8'($urandom_range(0, 4));
        end
        @(negedge clk);
        {cmd_arm, cmd_disarm, cmd_stat_wr, cmd_prog, cmd_sect_erase, cmd_chip_erase} = '0;
        settle(8);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule